// File: doc/BRIEF.md
# Commit-Gated Store Queue

This block keeps the stores of an out-of-order core in program order from dispatch until they are written to memory. Dispatch takes a slot at the tail and receives that slot's number. The execute stage later uses the number to write the store's address, and a separate port writes its data. The two writes may come in either order. Each slot also records the set of unresolved branches that the store was speculated under.

The reorder buffer raises a commit pulse when the oldest unretired store reaches retirement. The pulse takes effect only if that store already holds both its address and its data. Retired stores are presented one at a time, oldest first, on a valid/ready write port, and the queue head moves only when the port accepts a store. A misprediction kill names one or more branch bits. Every unretired slot tagged with one of those bits is discarded, and the tail moves back so that the freed slots are handed out again.

Top module: `stq_commit_queue`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `mem_req_valid` is 0 and `alloc_idx` is 0.
- R2: An allocation is taken when `alloc_valid` is high, `full` is low and `kill_valid` is low. The slot it receives is the `alloc_idx` value shown in that cycle, and slot numbers increase by one and wrap from DEPTH-1 to 0.
- R3: `full` is high while DEPTH stores are held. An allocation attempt while full changes neither `alloc_idx` nor `full`.
- R4: Address and data writes select a slot by its number and may arrive in either order. The write port later delivers exactly the values written to that slot.
- R5: A commit pulse retires the oldest unretired store only if both its address and its data are present. Otherwise the pulse is ignored and nothing reaches the write port.
- R6: Only retired stores are offered on the write port, oldest first. While `mem_req_ready` is low the offered address and data stay unchanged.
- R7: The head leaves the queue only in a cycle where `mem_req_valid` and `mem_req_ready` are both high.
- R8: A kill invalidates every unretired slot whose branch mask shares a bit with `kill_brmask`. The tail moves back to the oldest killed slot, so the next allocation receives that slot number. An allocation requested in the kill cycle is dropped.
- R9: A retired store that is still waiting for the write port is never removed by a kill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_brmask | input | BR_W | Branches the new store is speculated under |
| alloc_idx | output | IW | Slot number given to an allocation in this cycle |
| full | output | 1 | Queue holds DEPTH stores |
| addr_wr_valid | input | 1 | Address write strobe |
| addr_wr_idx | input | IW | Slot receiving the address |
| addr_wr_value | input | AW | Computed store address |
| data_wr_valid | input | 1 | Data write strobe |
| data_wr_idx | input | IW | Slot receiving the data |
| data_wr_value | input | DW | Store data |
| commit | input | 1 | Reorder buffer retires the oldest unretired store |
| kill_valid | input | 1 | Branch misprediction kill |
| kill_brmask | input | BR_W | Branch bits being killed |
| mem_req_valid | output | 1 | A retired store is offered to memory |
| mem_req_addr | output | AW | Address of the offered store |
| mem_req_data | output | DW | Data of the offered store |
| mem_req_ready | input | 1 | Memory accepts the offered store |

## Verification
The assertions check on every cycle that:
- the write port holds its offer steady while stalled;
- a write request appears only after a commit pulse;
- a full queue stays full unless a store drains or a kill occurs;
- the allocation slot steps by exactly one after each accepted allocation;
- a pending retired store survives a kill.

Only the bench scenarios can show the following:
- address and data written in either order reach the port intact;
- a commit is refused while the data is missing;
- killed slots are handed out again in order;
- stores drain oldest first through pointer wrap-around.

// File: rtl/stq_pkg.sv
package stq_pkg;

    // Per-slot status flags
    typedef struct packed {
        logic valid;    // slot holds a live store
        logic retired;  // committed, waiting for the memory port
        logic addr_ok;  // address written
        logic data_ok;  // data written
    } stq_flags_t;

endpackage

// File: rtl/stq_kill_scan.sv
// Finds the unretired slots hit by a kill and how many live stores precede the first hit.
module stq_kill_scan #(
    parameter int DEPTH = 8,
    parameter int BR_W  = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [IW-1:0]              head,
    input  logic [CW-1:0]              cnt,
    input  logic [DEPTH-1:0]           live_vec,
    input  logic [DEPTH-1:0]           guard_vec,
    input  logic [DEPTH-1:0][BR_W-1:0] masks,
    input  logic                       kill_valid,
    input  logic [BR_W-1:0]            kill_brmask,
    output logic [DEPTH-1:0]           hit_vec,
    output logic [CW-1:0]              keep_cnt
);
    logic        found;
    int unsigned pos;

    always_comb begin
        hit_vec  = '0;
        keep_cnt = cnt;
        found    = 1'b0;
        pos      = 0;
        for (int i = 0; i < DEPTH; i++) begin
            pos = int'(head) + i;
            if (pos >= DEPTH) pos = pos - DEPTH;
            if (kill_valid && (CW'(i) < cnt) && live_vec[IW'(pos)] &&
                !guard_vec[IW'(pos)] && (|(masks[IW'(pos)] & kill_brmask))) begin
                hit_vec[IW'(pos)] = 1'b1;
                if (!found) begin
                    found    = 1'b1;
                    keep_cnt = CW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/stq_drain.sv
// Presents the head slot to the memory write port once it is retired.
module stq_drain #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [IW-1:0]            head,
    input  logic [CW-1:0]            retired_cnt,
    input  logic [DEPTH-1:0][AW-1:0] adr,
    input  logic [DEPTH-1:0][DW-1:0] dat,
    input  logic                     mem_req_ready,
    output logic                     mem_req_valid,
    output logic [AW-1:0]            mem_req_addr,
    output logic [DW-1:0]            mem_req_data,
    output logic                     fire
);
    always_comb begin
        mem_req_valid = (retired_cnt != '0);
        mem_req_addr  = adr[head];
        mem_req_data  = dat[head];
        fire          = mem_req_valid && mem_req_ready;
    end
endmodule

// File: rtl/stq_commit_queue.sv
// Store queue: allocate at tail, fill address/data by slot, retire on commit, drain at head.
// DEPTH must be a power of two.
module stq_commit_queue
    import stq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int BR_W  = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic [BR_W-1:0] alloc_brmask,
    output logic [IW-1:0]   alloc_idx,
    output logic            full,
    input  logic            addr_wr_valid,
    input  logic [IW-1:0]   addr_wr_idx,
    input  logic [AW-1:0]   addr_wr_value,
    input  logic            data_wr_valid,
    input  logic [IW-1:0]   data_wr_idx,
    input  logic [DW-1:0]   data_wr_value,
    input  logic            commit,
    input  logic            kill_valid,
    input  logic [BR_W-1:0] kill_brmask,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_req_addr,
    output logic [DW-1:0]   mem_req_data,
    input  logic            mem_req_ready
);
    typedef struct packed {
        stq_flags_t [DEPTH-1:0]           flg;
        logic       [DEPTH-1:0][BR_W-1:0] msk;
        logic       [DEPTH-1:0][AW-1:0]   adr;
        logic       [DEPTH-1:0][DW-1:0]   dat;
        logic       [IW-1:0]              head;
        logic       [IW-1:0]              tail;
        logic       [IW-1:0]              cptr;
        logic       [CW-1:0]              cnt;
        logic       [CW-1:0]              ncmt;
    } state_t;

    state_t st_d, st_q;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic             cmt_ok;
    logic             alloc_ok;
    logic             fire;
    logic [DEPTH-1:0] live_vec;
    logic [DEPTH-1:0] guard_vec;
    logic [DEPTH-1:0] hit_vec;
    logic [CW-1:0]    keep_cnt;

    // Commit qualification and the set of slots a kill must spare
    always_comb begin
        cmt_ok = commit && (st_q.cnt != st_q.ncmt) &&
                 st_q.flg[st_q.cptr].addr_ok && st_q.flg[st_q.cptr].data_ok;
        for (int i = 0; i < DEPTH; i++) begin
            live_vec[i]  = st_q.flg[i].valid;
            guard_vec[i] = st_q.flg[i].retired || (cmt_ok && (st_q.cptr == IW'(i)));
        end
    end

    assign full      = (st_q.cnt == CW'(DEPTH));
    assign alloc_idx = st_q.tail;
    assign alloc_ok  = alloc_valid && !full && !kill_valid;

    stq_kill_scan #(.DEPTH(DEPTH), .BR_W(BR_W)) u_scan (
        .head        (st_q.head),
        .cnt         (st_q.cnt),
        .live_vec    (live_vec),
        .guard_vec   (guard_vec),
        .masks       (st_q.msk),
        .kill_valid  (kill_valid),
        .kill_brmask (kill_brmask),
        .hit_vec     (hit_vec),
        .keep_cnt    (keep_cnt)
    );

    stq_drain #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_drain (
        .head          (st_q.head),
        .retired_cnt   (st_q.ncmt),
        .adr           (st_q.adr),
        .dat           (st_q.dat),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .fire          (fire)
    );

    always_comb begin
        st_d = st_q;

        // Execute-side writes land only in live, unretired slots
        if (addr_wr_valid && st_q.flg[addr_wr_idx].valid && !st_q.flg[addr_wr_idx].retired) begin
            st_d.adr[addr_wr_idx]         = addr_wr_value;
            st_d.flg[addr_wr_idx].addr_ok = 1'b1;
        end
        if (data_wr_valid && st_q.flg[data_wr_idx].valid && !st_q.flg[data_wr_idx].retired) begin
            st_d.dat[data_wr_idx]         = data_wr_value;
            st_d.flg[data_wr_idx].data_ok = 1'b1;
        end

        // Retirement
        if (cmt_ok) begin
            st_d.flg[st_q.cptr].retired = 1'b1;
            st_d.cptr                   = bump(st_q.cptr);
        end

        // Drain at head
        if (fire) begin
            st_d.flg[st_q.head] = '0;
            st_d.head           = bump(st_q.head);
        end

        // Kill has priority over allocation
        if (kill_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit_vec[i]) st_d.flg[i] = '0;
            end
            st_d.tail = st_q.head + keep_cnt[IW-1:0];
            st_d.cnt  = keep_cnt - CW'(fire);
        end else if (alloc_ok) begin
            st_d.flg[st_q.tail]       = '0;
            st_d.flg[st_q.tail].valid = 1'b1;
            st_d.msk[st_q.tail]       = alloc_brmask;
            st_d.tail                 = bump(st_q.tail);
            st_d.cnt                  = st_q.cnt + 1'b1 - CW'(fire);
        end else begin
            st_d.cnt = st_q.cnt - CW'(fire);
        end

        st_d.ncmt = st_q.ncmt + CW'(cmt_ok) - CW'(fire);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stq_commit_queue_chk.sv
module stq_commit_queue_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          full,
    input logic [IW-1:0] alloc_idx,
    input logic          kill_valid,
    input logic          commit,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic [DW-1:0] mem_req_data
);
    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    p_alloc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && !full && !kill_valid |=> alloc_idx == nxt($past(alloc_idx)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full && !(mem_req_valid && mem_req_ready) && !kill_valid |=> full);

    p_req_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(commit));

    p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));

    p_retired_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && kill_valid && !mem_req_ready |=> mem_req_valid);
endmodule

bind stq_commit_queue stq_commit_queue_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .full          (full),
    .alloc_idx     (alloc_idx),
    .kill_valid    (kill_valid),
    .commit        (commit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data)
);

// File: tb/stq_commit_queue_tb.sv
module stq_commit_queue_tb;
    localparam int DEPTH = 8;
    localparam int BR_W  = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int IW    = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            alloc_valid;
    logic [BR_W-1:0] alloc_brmask;
    logic [IW-1:0]   alloc_idx;
    logic            full;
    logic            addr_wr_valid;
    logic [IW-1:0]   addr_wr_idx;
    logic [AW-1:0]   addr_wr_value;
    logic            data_wr_valid;
    logic [IW-1:0]   data_wr_idx;
    logic [DW-1:0]   data_wr_value;
    logic            commit;
    logic            kill_valid;
    logic [BR_W-1:0] kill_brmask;
    logic            mem_req_valid;
    logic [AW-1:0]   mem_req_addr;
    logic [DW-1:0]   mem_req_data;
    logic            mem_req_ready;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    stq_commit_queue #(.DEPTH(DEPTH), .BR_W(BR_W), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_brmask(alloc_brmask),
        .alloc_idx(alloc_idx), .full(full),
        .addr_wr_valid(addr_wr_valid), .addr_wr_idx(addr_wr_idx), .addr_wr_value(addr_wr_value),
        .data_wr_valid(data_wr_valid), .data_wr_idx(data_wr_idx), .data_wr_value(data_wr_value),
        .commit(commit), .kill_valid(kill_valid), .kill_brmask(kill_brmask),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .mem_req_ready(mem_req_ready)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] d;
        logic        afirst;
        logic [2:0]  stall;
    } vec_t;

    localparam vec_t VEC [0:9] = '{
        '{32'h1000_0000, 32'hA5A5_0001, 1'b1, 3'd0},
        '{32'h1000_0004, 32'h5A5A_0002, 1'b0, 3'd2},
        '{32'h2000_0010, 32'hDEAD_BEEF, 1'b1, 3'd1},
        '{32'h3000_0020, 32'h0000_0000, 1'b0, 3'd0},
        '{32'hFFFF_FFFC, 32'hFFFF_FFFF, 1'b1, 3'd3},
        '{32'h0000_0000, 32'h1234_5678, 1'b0, 3'd1},
        '{32'h4000_0100, 32'h8765_4321, 1'b1, 3'd0},
        '{32'h5000_0200, 32'hCAFE_F00D, 1'b0, 3'd4},
        '{32'h6000_0300, 32'h0BAD_C0DE, 1'b1, 3'd0},
        '{32'h7000_0400, 32'h0F0F_0F0F, 1'b0, 3'd2}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; alloc_valid = 0; alloc_brmask = '0;
        addr_wr_valid = 0; addr_wr_idx = '0; addr_wr_value = '0;
        data_wr_valid = 0; data_wr_idx = '0; data_wr_value = '0;
        commit = 0; kill_valid = 0; kill_brmask = '0; mem_req_ready = 0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic alloc_one(input logic [BR_W-1:0] m, output logic [IW-1:0] idx);
        alloc_valid = 1'b1; alloc_brmask = m; idx = alloc_idx;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic wr_addr(input logic [IW-1:0] i, input logic [AW-1:0] v);
        addr_wr_valid = 1'b1; addr_wr_idx = i; addr_wr_value = v;
        step();
        addr_wr_valid = 1'b0;
    endtask

    task automatic wr_data(input logic [IW-1:0] i, input logic [DW-1:0] v);
        data_wr_valid = 1'b1; data_wr_idx = i; data_wr_value = v;
        step();
        data_wr_valid = 1'b0;
    endtask

    task automatic do_commit();
        commit = 1'b1;
        step();
        commit = 1'b0;
    endtask

    task automatic do_kill(input logic [BR_W-1:0] m);
        kill_valid = 1'b1; kill_brmask = m;
        step();
        kill_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R1 act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [IW-1:0] idx, s0, s1, s2;

        // R1: reset state
        do_reset();
        chk(full == 1'b0, "R1 full after reset", 32'(full), 0);
        chk(mem_req_valid == 1'b0, "R1 req after reset", 32'(mem_req_valid), 0);
        chk(alloc_idx == '0, "R1 alloc_idx after reset", 32'(alloc_idx), 0);

        // Vector walk: R2 slot order with wrap, R4 either write order, R6 stall, R7 drain
        for (int i = 0; i < 10; i++) begin
            alloc_one(4'b0000, idx);
            chk(int'(idx) == i % DEPTH, "R2 slot number", 32'(idx), 32'(i % DEPTH));
            if (VEC[i].afirst) begin
                wr_addr(idx, VEC[i].a);
                wr_data(idx, VEC[i].d);
            end else begin
                wr_data(idx, VEC[i].d);
                wr_addr(idx, VEC[i].a);
            end
            do_commit();
            chk(mem_req_valid == 1'b1, "R5 offer after commit", 32'(mem_req_valid), 1);
            for (int k = 0; k < int'(VEC[i].stall); k++) begin
                step();
                chk(mem_req_valid && mem_req_addr == VEC[i].a, "R6 stable while stalled",
                    mem_req_addr, VEC[i].a);
            end
            chk(mem_req_addr == VEC[i].a, "R4 address delivered", mem_req_addr, VEC[i].a);
            chk(mem_req_data == VEC[i].d, "R4 data delivered", mem_req_data, VEC[i].d);
            mem_req_ready = 1'b1;
            step();
            mem_req_ready = 1'b0;
            chk(mem_req_valid == 1'b0, "R7 head drained", 32'(mem_req_valid), 0);
        end

        // R3: fill to capacity, then try once more
        do_reset();
        for (int i = 0; i < DEPTH; i++) alloc_one(4'b0000, idx);
        chk(full == 1'b1, "R3 full at depth", 32'(full), 1);
        alloc_one(4'b0000, idx);
        chk(full == 1'b1, "R3 still full", 32'(full), 1);
        chk(alloc_idx == '0, "R3 alloc while full ignored", 32'(alloc_idx), 0);

        // R5: commit refused without data; R6/R7: oldest first, head waits for ready
        do_reset();
        alloc_one(4'b0000, s0);
        alloc_one(4'b0000, s1);
        wr_addr(s0, 32'hAAAA_0000);
        do_commit();
        chk(mem_req_valid == 1'b0, "R5 commit without data ignored", 32'(mem_req_valid), 0);
        wr_data(s1, 32'h2222_2222);
        wr_addr(s1, 32'hBBBB_0000);
        wr_data(s0, 32'h1111_1111);
        do_commit();
        do_commit();
        step();
        chk(mem_req_valid && mem_req_addr == 32'hAAAA_0000, "R7 head held without ready",
            mem_req_addr, 32'hAAAA_0000);
        mem_req_ready = 1'b1;
        chk(mem_req_addr == 32'hAAAA_0000, "R6 oldest first", mem_req_addr, 32'hAAAA_0000);
        step();
        chk(mem_req_addr == 32'hBBBB_0000 && mem_req_data == 32'h2222_2222,
            "R6 second store next", mem_req_addr, 32'hBBBB_0000);
        step();
        mem_req_ready = 1'b0;
        chk(mem_req_valid == 1'b0, "R7 queue empty", 32'(mem_req_valid), 0);

        // R8/R9: kill younger stores, keep the retired one
        do_reset();
        alloc_one(4'b0001, s0);
        alloc_one(4'b0011, s1);
        alloc_one(4'b0011, s2);
        wr_addr(s0, 32'hC0C0_0000);
        wr_data(s0, 32'h0000_00C0);
        do_commit();
        wr_addr(s1, 32'hD1D1_0000);
        alloc_valid = 1'b1; alloc_brmask = 4'b0000;
        do_kill(4'b0010);
        alloc_valid = 1'b0;
        chk(alloc_idx == s1, "R8 tail rolled back", 32'(alloc_idx), 32'(s1));
        chk(full == 1'b0, "R8 not full after kill", 32'(full), 0);
        chk(mem_req_valid && mem_req_addr == 32'hC0C0_0000, "R9 retired store kept",
            mem_req_addr, 32'hC0C0_0000);
        do_kill(4'b0001);
        chk(mem_req_valid == 1'b1, "R9 retired store survives own bit", 32'(mem_req_valid), 1);
        chk(alloc_idx == s1, "R8 no retired slot rolled back", 32'(alloc_idx), 32'(s1));
        alloc_one(4'b0000, idx);
        chk(idx == s1, "R8 killed slot reused", 32'(idx), 32'(s1));
        do_commit();
        mem_req_ready = 1'b1;
        step();
        mem_req_ready = 1'b0;
        chk(mem_req_valid == 1'b0, "R8 reused slot starts without address", 32'(mem_req_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule